// File: doc/BRIEF.md
# Pixel Point-Operation ALU with Result Shifter

This block applies a per-pixel point operation to an 8-bit image stream before the stream enters a convolution stage. Each incoming pixel is operand A. Operand B is a constant held in a register that captures a shared configuration bus when its load enable is high. A 10-bit microcode word chooses the operation and a shift. The low 7 bits pick one of a small set of operations: pass, saturating add or subtract, AND, OR and XOR. The top 3 bits pick a left or right shift, which acts on the operation's result whatever that operation is.

The microcode word and the data-format flag share the configuration bus with the constant register. They are written in two byte-wide halves under a chip-select, a load strobe and an address bit. Arithmetic saturates to the range of the active format, either unsigned or two's complement. The processed pixel leaves through a register, so the latency is one clock.

Top module: `pix_point_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pix_out`, the constant, the microcode and the format flag are all zero. The microcode value zero means pass A with no shift, and the format flag zero means unsigned.
- R2: On a rising clock edge with `alu_ld` high, the constant register captures `cfg_bus`. With `alu_ld` low it keeps its value, whatever `cfg_bus` carries.
- R3: An edge with `ctl_cs` and `ctl_ld` both high writes the control register. With `ctl_addr`=0, `cfg_bus[7:0]` goes to microcode bits [7:0]. With `ctl_addr`=1, `cfg_bus[1:0]` goes to microcode bits [9:8] and `cfg_bus[2]` goes to the format flag, where 1 means two's complement. If either strobe is low, nothing is written.
- R4: Microcode bits [6:0] select the operation: 0 pass A, 1 pass B, 2 A+B, 3 A−B, 4 B−A, 5 A AND B, 6 A OR B, 7 A XOR B. Every other code passes A.
- R5: In unsigned format, codes 2 to 4 clamp their result to 0..255.
- R6: In two's-complement format, codes 2 to 4 clamp their result to −128..127, that is 0x80..0x7F.
- R7: Microcode bits [9:7] select the shift, which is applied after the operation and its saturation. 000 means no shift. 001 to 011 shift left by 1 to 3, filling with zeros and dropping the bits that leave the top. 100 to 111 shift right by 1 to 4, filling with zeros in unsigned format and with copies of the sign bit in two's-complement format.
- R8: The configuration bus is shared. If an edge has `alu_ld` high and also has `ctl_cs` and `ctl_ld` high, it writes the same bus value into both the constant register and the addressed control field.
- R9: `pix_out` shows the result for the `pix_in` value sampled at the previous rising edge, using the configuration present at that edge. Back-to-back pixels give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_in | input | 8 | Incoming pixel, operand A |
| cfg_bus | input | 8 | Shared configuration bus |
| alu_ld | input | 1 | Load enable for the constant register |
| ctl_cs | input | 1 | Control register chip-select |
| ctl_ld | input | 1 | Control register load strobe |
| ctl_addr | input | 1 | Control half select: 0 low byte, 1 high bits and format |
| pix_out | output | 8 | Processed pixel, registered |

## Verification
The bench builds the block with its default parameters: an 8-bit pixel and a 10-bit microcode word. At this width every saturation rail can be hit with a single pixel: 255 and 0 in unsigned format, 0x7F and 0x80 in two's complement. Each of the eight shift codes can also be shown to drop high bits or fill with sign bits on values the bench chooses. The 2-bit high half of the microcode also lets the bench show that a write with the strobes split leaves the word unchanged, and that a write colliding with a constant load lands in both registers.

// File: rtl/pix_alu_pkg.sv
package pix_alu_pkg;
  localparam int SHIFT_W = 3;
  localparam int OP_W    = 7;
  localparam int UCODE_W = SHIFT_W + OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_PASS_A = 7'd0,
    OP_PASS_B = 7'd1,
    OP_ADD    = 7'd2,
    OP_SUB_AB = 7'd3,
    OP_SUB_BA = 7'd4,
    OP_AND    = 7'd5,
    OP_OR     = 7'd6,
    OP_XOR    = 7'd7
  } alu_op_e;
endpackage

// File: rtl/pix_cfg_regs.sv
module pix_cfg_regs
  import pix_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  cfg_bus,
  input  logic               alu_ld,
  input  logic               ctl_cs,
  input  logic               ctl_ld,
  input  logic               ctl_addr,
  output logic [DATA_W-1:0]  const_q,
  output logic [UCODE_W-1:0] ucode_q,
  output logic               fmt_signed_q
);
  localparam int HI_W = UCODE_W - DATA_W;

  logic wr_lo, wr_hi;
  assign wr_lo = ctl_cs & ctl_ld & ~ctl_addr;
  assign wr_hi = ctl_cs & ctl_ld &  ctl_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) const_q <= '0;
    else if (alu_ld) const_q <= cfg_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ucode_q      <= '0;
      fmt_signed_q <= 1'b0;
    end else begin
      if (wr_lo) ucode_q[DATA_W-1:0] <= cfg_bus;
      if (wr_hi) begin
        ucode_q[UCODE_W-1:DATA_W] <= cfg_bus[HI_W-1:0];
        fmt_signed_q              <= cfg_bus[HI_W];
      end
    end
  end

  assert_const_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_ld |=> $stable(const_q));
  assert_const_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alu_ld |=> const_q == $past(cfg_bus));
  assert_ctl_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_cs && ctl_ld) |=> $stable(ucode_q) && $stable(fmt_signed_q));
  assert_shared_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alu_ld && wr_lo |=> ucode_q[DATA_W-1:0] == const_q);
endmodule

// File: rtl/pix_alu_core.sv
module pix_alu_core
  import pix_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [OP_W-1:0]   op_sel,
  input  logic              fmt_signed,
  output logic [DATA_W-1:0] alu_res,
  output logic              sat_hit
);
  localparam int EW = DATA_W + 2;
  localparam logic signed [EW-1:0] UMAX = EW'((1 << DATA_W) - 1);
  localparam logic signed [EW-1:0] SMAX = EW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [EW-1:0] SMIN = EW'(-(1 << (DATA_W - 1)));

  function automatic logic signed [EW-1:0] widen(input logic [DATA_W-1:0] v,
                                                 input logic sgn);
    return sgn ? {{2{v[DATA_W-1]}}, v} : {2'b00, v};
  endfunction

  function automatic logic over_rail(input logic signed [EW-1:0] x,
                                     input logic sgn);
    logic signed [EW-1:0] hi, lo;
    hi = sgn ? SMAX : UMAX;
    lo = sgn ? SMIN : '0;
    return (x > hi) || (x < lo);
  endfunction

  function automatic logic [DATA_W-1:0] clamp(input logic signed [EW-1:0] x,
                                              input logic sgn);
    logic signed [EW-1:0] hi, lo;
    hi = sgn ? SMAX : UMAX;
    lo = sgn ? SMIN : '0;
    if (x > hi) return hi[DATA_W-1:0];
    if (x < lo) return lo[DATA_W-1:0];
    return x[DATA_W-1:0];
  endfunction

  logic signed [EW-1:0] ea, eb, wide;
  logic                 is_arith;

  always_comb begin
    ea       = widen(op_a, fmt_signed);
    eb       = widen(op_b, fmt_signed);
    wide     = '0;
    is_arith = 1'b0;
    alu_res  = op_a;
    case (op_sel)
      OP_PASS_A: alu_res = op_a;
      OP_PASS_B: alu_res = op_b;
      OP_ADD:    begin wide = ea + eb; is_arith = 1'b1; end
      OP_SUB_AB: begin wide = ea - eb; is_arith = 1'b1; end
      OP_SUB_BA: begin wide = eb - ea; is_arith = 1'b1; end
      OP_AND:    alu_res = op_a & op_b;
      OP_OR:     alu_res = op_a | op_b;
      OP_XOR:    alu_res = op_a ^ op_b;
      default:   alu_res = op_a;
    endcase
    if (is_arith) alu_res = clamp(wide, fmt_signed);
    sat_hit = is_arith && over_rail(wide, fmt_signed);
  end
endmodule

// File: rtl/pix_result_shift.sv
module pix_result_shift
  import pix_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHIFT_W-1:0] sh_code,
  input  logic               fmt_signed,
  output logic [DATA_W-1:0]  dout
);
  function automatic logic [DATA_W-1:0] do_shift(input logic [DATA_W-1:0] v,
                                                 input logic [SHIFT_W-1:0] code,
                                                 input logic sgn);
    logic [SHIFT_W-1:0] amt;
    if (!code[SHIFT_W-1]) begin
      amt = {1'b0, code[SHIFT_W-2:0]};
      return v << amt;
    end
    amt = {1'b0, code[SHIFT_W-2:0]} + SHIFT_W'(1);
    if (sgn) return DATA_W'($signed(v) >>> amt);
    return v >> amt;
  endfunction

  assign dout = do_shift(din, sh_code, fmt_signed);
endmodule

// File: rtl/pix_point_alu.sv
module pix_point_alu
  import pix_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pix_in,
  input  logic [DATA_W-1:0] cfg_bus,
  input  logic              alu_ld,
  input  logic              ctl_cs,
  input  logic              ctl_ld,
  input  logic              ctl_addr,
  output logic [DATA_W-1:0] pix_out
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [DATA_W-1:0] S_MAX    = ALL_ONES >> 1;
  localparam logic [DATA_W-1:0] S_MIN    = ~S_MAX;

  logic [DATA_W-1:0]  const_q;
  logic [UCODE_W-1:0] ucode_q;
  logic               fmt_signed_q;
  logic [DATA_W-1:0]  alu_res, shifted;
  logic               sat_hit;
  logic [SHIFT_W-1:0] sh_code;
  logic [OP_W-1:0]    op_sel;

  assign sh_code = ucode_q[UCODE_W-1:OP_W];
  assign op_sel  = ucode_q[OP_W-1:0];

  pix_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_bus(cfg_bus), .alu_ld(alu_ld),
    .ctl_cs(ctl_cs), .ctl_ld(ctl_ld), .ctl_addr(ctl_addr),
    .const_q(const_q), .ucode_q(ucode_q), .fmt_signed_q(fmt_signed_q)
  );

  pix_alu_core #(.DATA_W(DATA_W)) u_core (
    .op_a(pix_in), .op_b(const_q), .op_sel(op_sel),
    .fmt_signed(fmt_signed_q), .alu_res(alu_res), .sat_hit(sat_hit)
  );

  pix_result_shift #(.DATA_W(DATA_W)) u_shift (
    .din(alu_res), .sh_code(sh_code), .fmt_signed(fmt_signed_q),
    .dout(shifted)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= '0;
    else        pix_out <= shifted;
  end

  assert_pass_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_q == '0 |=> pix_out == $past(pix_in));
  assert_no_wrap_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ucode_q == UCODE_W'(OP_ADD)) && !fmt_signed_q |=> pix_out >= $past(pix_in));
  assert_sat_rail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit && sh_code == '0 && !fmt_signed_q |=> pix_out == '0 || pix_out == ALL_ONES);
  assert_sat_rail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit && sh_code == '0 && fmt_signed_q |=> pix_out == S_MAX || pix_out == S_MIN);
endmodule

// File: tb/tb_pix_point_alu.sv
module tb_pix_point_alu;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pix_in = '0, cfg_bus = '0;
  logic       alu_ld = 1'b0, ctl_cs = 1'b0, ctl_ld = 1'b0, ctl_addr = 1'b0;
  logic [7:0] pix_out;
  int n_chk = 0, n_bad = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_point_alu dut (
    .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .cfg_bus(cfg_bus),
    .alu_ld(alu_ld), .ctl_cs(ctl_cs), .ctl_ld(ctl_ld), .ctl_addr(ctl_addr),
    .pix_out(pix_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int model(int a, int b, int op, int sh, bit sgn);
    int sa, sb, r, v, n;
    sa = (sgn && a > 127) ? a - 256 : a;
    sb = (sgn && b > 127) ? b - 256 : b;
    case (op)
      1: r = b;
      2: r = sa + sb;
      3: r = sa - sb;
      4: r = sb - sa;
      5: r = a & b;
      6: r = a | b;
      7: r = a ^ b;
      default: r = a;
    endcase
    if (op >= 2 && op <= 4) begin
      if (sgn) begin if (r > 127) r = 127; if (r < -128) r = -128; end
      else     begin if (r > 255) r = 255; if (r < 0) r = 0; end
    end
    v = r & 255;
    if (sh >= 1 && sh <= 3) v = (v << sh) & 255;
    else if (sh >= 4) begin
      n = sh - 3;
      if (sgn && v > 127) v = ((v - 256) >>> n) & 255;
      else v = v >> n;
    end
    return v;
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr_ctl(bit addr, int data);
    @(negedge clk);
    ctl_cs = 1'b1; ctl_ld = 1'b1; ctl_addr = addr; cfg_bus = 8'(data);
    @(negedge clk);
    ctl_cs = 1'b0; ctl_ld = 1'b0;
  endtask

  task automatic set_mode(int op, int sh, bit sgn);
    int uc;
    uc = (sh << 7) | op;
    wr_ctl(1'b0, uc & 255);
    wr_ctl(1'b1, (uc >> 8) | (int'(sgn) << 2));
  endtask

  task automatic ld_const(int v);
    @(negedge clk);
    alu_ld = 1'b1; cfg_bus = 8'(v);
    @(negedge clk);
    alu_ld = 1'b0;
  endtask

  task automatic apply(int a, output int got);
    @(negedge clk);
    pix_in = 8'(a);
    @(negedge clk);
    got = int'(pix_out);
  endtask

  task automatic t_reset;
    int got;
    check("R1 pix_out in reset", int'(pix_out), 0);
    @(negedge clk); rst_n = 1'b1;
    check("R1 pix_out after release", int'(pix_out), 0);
    apply(8'h5A, got);
    check("R1 default pass A", got, 8'h5A);
    set_mode(1, 0, 1'b0);
    apply(8'h11, got);
    check("R1 constant resets to zero", got, 0);
  endtask

  task automatic t_const;
    int got;
    ld_const(8'h33);
    apply(8'hFF, got);
    check("R2 constant loaded", got, 8'h33);
    @(negedge clk); cfg_bus = 8'h77;
    apply(8'h01, got);
    check("R2 constant held with alu_ld low", got, 8'h33);
  endtask

  task automatic t_ctl_gate;
    int got;
    @(negedge clk);
    ctl_cs = 1'b1; ctl_ld = 1'b0; ctl_addr = 1'b0; cfg_bus = 8'h00;
    @(negedge clk);
    ctl_cs = 1'b0; ctl_ld = 1'b1;
    @(negedge clk);
    ctl_ld = 1'b0;
    apply(8'h44, got);
    check("R3 split strobes leave microcode", got, 8'h33);
    wr_ctl(1'b0, 8'h00);
    apply(8'h44, got);
    check("R3 low byte write selects pass A", got, 8'h44);
  endtask

  task automatic t_ops;
    int got;
    int avals[4] = '{8'h3C, 8'hF0, 8'h05, 8'h81};
    int bvals[2] = '{8'h5A, 8'h90};
    int ops[10]  = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 127};
    for (int s = 0; s < 2; s++)
      for (int bi = 0; bi < 2; bi++) begin
        ld_const(bvals[bi]);
        for (int oi = 0; oi < 10; oi++) begin
          set_mode(ops[oi], 0, 1'(s));
          for (int ai = 0; ai < 4; ai++) begin
            apply(avals[ai], got);
            check("R4 opcode result", got, model(avals[ai], bvals[bi], ops[oi], 0, 1'(s)));
          end
        end
      end
  endtask

  task automatic t_sat;
    int got;
    set_mode(2, 0, 1'b0); ld_const(100);
    apply(200, got); check("R5 unsigned add clamps high", got, 255);
    set_mode(3, 0, 1'b0); ld_const(20);
    apply(10, got);  check("R5 unsigned A-B clamps low", got, 0);
    set_mode(4, 0, 1'b0); ld_const(10);
    apply(30, got);  check("R5 unsigned B-A clamps low", got, 0);
    set_mode(2, 0, 1'b1); ld_const(100);
    apply(100, got); check("R6 signed add clamps 0x7F", got, 8'h7F);
    set_mode(3, 0, 1'b1); ld_const(8'h64);
    apply(8'h9C, got); check("R6 signed sub clamps 0x80", got, 8'h80);
    set_mode(2, 0, 1'b1); ld_const(8'hFB);
    apply(3, got);   check("R6 signed add in range", got, 8'hFE);
  endtask

  task automatic t_shift;
    int got;
    ld_const(8'h0F);
    for (int s = 0; s < 2; s++)
      for (int sh = 0; sh < 8; sh++) begin
        set_mode(7, sh, 1'(s));
        apply(8'h5F, got);
        check("R7 shift after xor", got, model(8'h5F, 8'h0F, 7, sh, 1'(s)));
      end
    set_mode(2, 1, 1'b0); ld_const(8'hC0);
    apply(8'h80, got);
    check("R7 left shift after saturating add", got, 8'hFE);
    set_mode(0, 7, 1'b1);
    apply(8'h80, got);
    check("R7 signed right shift by 4 fills sign", got, 8'hF8);
  endtask

  task automatic t_hazard;
    int got;
    set_mode(0, 0, 1'b0);
    @(negedge clk);
    alu_ld = 1'b1; ctl_cs = 1'b1; ctl_ld = 1'b1; ctl_addr = 1'b0; cfg_bus = 8'h02;
    @(negedge clk);
    alu_ld = 1'b0; ctl_cs = 1'b0; ctl_ld = 1'b0;
    apply(5, got);
    check("R8 shared bus wrote both registers (A+2)", got, 7);
  endtask

  task automatic t_latency;
    int vals[6] = '{8'h10, 8'h20, 8'hE0, 8'h7F, 8'h80, 8'h01};
    set_mode(2, 0, 1'b0); ld_const(8'h30);
    @(negedge clk);
    pix_in = 8'(vals[0]);
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      check("R9 one-cycle latency stream", int'(pix_out), model(vals[i-1], 8'h30, 2, 0, 1'b0));
      pix_in = 8'(vals[i]);
    end
    @(negedge clk);
    check("R9 last stream result", int'(pix_out), model(vals[5], 8'h30, 2, 0, 1'b0));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_const();
    t_ctl_gate();
    t_ops();
    t_sat();
    t_shift();
    t_hazard();
    t_latency();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule